// File: doc/BRIEF.md
# Directory Home Controller for Shared-Memory Lines

This block sits at the home node of a distributed shared-memory system. It owns a group of memory lines, and for each line it keeps the line's data and a directory entry. The entry holds a coherence state and a presence vector with one bit per node. Requesting nodes send read or read-exclusive requests on a valid/ready channel. For each request the home does one of three things. It can answer at once with data. It can return the set of other holders, which the requester must invalidate. It can return the current owner, whom the requester must ask for the dirty copy.

The home itself never sends invalidations or interventions. The requester does that work. It reports that it has collected every invalidation acknowledgement on a completion channel. A dirty owner that has been asked for the line returns the data to the home on a writeback channel. A line stays busy from the moment the home hands out a holder set or an owner until the matching completion or writeback arrives. While a line is busy, every request to it is refused, and the requester retries later.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every line is invalid with an empty presence vector and is not busy, its data is zero, rsp_valid is 0, and req_ready is 1.
- R2: A read (req_kind 0) to an invalid line, or to a clean line held only by the requester, answers with rsp_kind 0 (exclusive data) and the stored data. The line becomes exclusive, with only the requester's bit set. Bit i of any node vector stands for node i.
- R3: A read to a clean line (exclusive or shared) that another node holds answers with rsp_kind 1 (shared data) and the stored data. The requester's bit is added, and the line becomes shared.
- R4: A read-exclusive (req_kind 1) to an invalid line, or to a clean line held only by the requester, answers with rsp_kind 2 (modified data) and the stored data. The line becomes modified, with only the requester's bit set.
- R5: A read-exclusive to a clean line that other nodes hold answers with rsp_kind 3. rsp_nodes lists the other holders, with the requester's bit clear, and rsp_data carries the stored data. The line turns busy. A completion from that requester for that line leaves the line modified with only the requester's bit set.
- R6: A read to a modified line answers with rsp_kind 4, and rsp_nodes has exactly the owner's bit set. The line turns busy. The owner's writeback stores the data and leaves the line shared by the old owner and the requester.
- R7: A read-exclusive to a modified line answers with rsp_kind 4 and the owner's bit, and the line turns busy. The owner's writeback stores the data and leaves the line modified with only the requester's bit set.
- R8: Any request to a busy line is answered with rsp_kind 5 (refused) and leaves the line's directory entry and data unchanged.
- R9: A writeback from the owner of a modified line that is not busy stores the data and leaves the line invalid with an empty presence vector.
- R10: A writeback from a node that does not own the line, and a completion from a node other than the one the line waits on, change nothing.
- R11: While rsp_valid is 1 and rsp_ready is 0, all response fields hold. req_ready is 0 while rsp_valid, wb_valid or cpl_valid is 1. cpl_ready is 0 while wb_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when also valid |
| req_kind | input | 1 | 0 read, 1 read-exclusive |
| req_src | input | NID_W | Requesting node |
| req_line | input | LID_W | Line index |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_kind | output | 3 | 0 exclusive data, 1 shared data, 2 modified data, 3 holder set, 4 owner, 5 refused |
| rsp_dst | output | NID_W | Node the response goes to |
| rsp_line | output | LID_W | Line the response is about |
| rsp_nodes | output | NODES | Holder set or owner bit, zero otherwise |
| rsp_data | output | DATA_W | Line data for kinds 0 to 3, zero otherwise |
| wb_valid | input | 1 | Writeback present |
| wb_ready | output | 1 | Writeback taken (always 1) |
| wb_src | input | NID_W | Node writing back |
| wb_line | input | LID_W | Line written back |
| wb_data | input | DATA_W | Written-back data |
| cpl_valid | input | 1 | Invalidation-complete notice present |
| cpl_ready | output | 1 | Notice taken |
| cpl_src | input | NID_W | Node reporting completion |
| cpl_line | input | LID_W | Line completed |

## Verification
The assertions watch several structural rules on every cycle. An invalid line never has holders. An exclusive or modified line has exactly one holder. A busy line is never invalid. A holder set never names the requester and is never empty. An owner reply names one node. A request accepted on a busy line is refused in the next cycle, and a stalled response holds its value. The bench scenarios are needed for the rest. Only they show whether the presence vector and the data evolve correctly across a whole transaction, because the outcome of a completion or writeback becomes visible only through the replies to later requests. The same holds for ignored messages from the wrong node: their lack of effect shows up only in those later replies.

// File: rtl/coh_home_pkg.sv
package coh_home_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_E = 2'd1,
        LS_S = 2'd2,
        LS_M = 2'd3
    } line_state_e;

    typedef enum logic [2:0] {
        RK_DATA_E  = 3'd0,
        RK_DATA_S  = 3'd1,
        RK_DATA_M  = 3'd2,
        RK_HOLDERS = 3'd3,
        RK_OWNER   = 3'd4,
        RK_REFUSE  = 3'd5
    } rsp_kind_e;

    typedef enum logic [1:0] {
        WT_NONE = 2'd0,
        WT_DONE = 2'd1,
        WT_WB_SHR = 2'd2,
        WT_WB_EXC = 2'd3
    } wait_e;

    localparam logic REQ_READ  = 1'b0;
    localparam logic REQ_READX = 1'b1;

    function automatic logic waits_on_owner(wait_e w);
        return (w == WT_WB_SHR) || (w == WT_WB_EXC);
    endfunction

endpackage

// File: rtl/coh_dir_store.sv
module coh_dir_store
    import coh_home_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int LINES  = 8,
    parameter int DATA_W = 16,
    parameter int NID_W  = 2,
    parameter int LID_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LID_W-1:0]  a_line,
    output line_state_e       a_state,
    output logic [NODES-1:0]  a_vec,
    output wait_e             a_wait,
    output logic [NID_W-1:0]  a_pend,
    output logic [DATA_W-1:0] a_data,
    input  logic [LID_W-1:0]  b_line,
    output line_state_e       b_state,
    output logic [NODES-1:0]  b_vec,
    output wait_e             b_wait,
    output logic [NID_W-1:0]  b_pend,
    input  logic              wr_en,
    input  logic [LID_W-1:0]  wr_line,
    input  line_state_e       wr_state,
    input  logic [NODES-1:0]  wr_vec,
    input  wait_e             wr_wait,
    input  logic [NID_W-1:0]  wr_pend,
    input  logic              wr_data_en,
    input  logic [DATA_W-1:0] wr_data
);

    line_state_e       st_q   [LINES];
    logic [NODES-1:0]  vec_q  [LINES];
    wait_e             wt_q   [LINES];
    logic [NID_W-1:0]  pend_q [LINES];
    logic [DATA_W-1:0] mem_q  [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic hit;
        assign hit = wr_en && (wr_line == LID_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[g]   <= LS_I;
                vec_q[g]  <= '0;
                wt_q[g]   <= WT_NONE;
                pend_q[g] <= '0;
                mem_q[g]  <= '0;
            end else if (hit) begin
                st_q[g]   <= wr_state;
                vec_q[g]  <= wr_vec;
                wt_q[g]   <= wr_wait;
                pend_q[g] <= wr_pend;
                if (wr_data_en) begin
                    mem_q[g] <= wr_data;
                end
            end
        end

        AST_INVALID_EMPTY: assert property (@(posedge clk) disable iff (rst)
            (st_q[g] == LS_I) |-> (vec_q[g] == '0)); // R9
        AST_SINGLE_HOLDER: assert property (@(posedge clk) disable iff (rst)
            ((st_q[g] == LS_M) || (st_q[g] == LS_E)) |-> ($countones(vec_q[g]) == 1)); // R4
        AST_BUSY_NOT_INVALID: assert property (@(posedge clk) disable iff (rst)
            (wt_q[g] != WT_NONE) |-> (st_q[g] != LS_I)); // R8
    end

    assign a_state = st_q[a_line];
    assign a_vec   = vec_q[a_line];
    assign a_wait  = wt_q[a_line];
    assign a_pend  = pend_q[a_line];
    assign a_data  = mem_q[a_line];
    assign b_state = st_q[b_line];
    assign b_vec   = vec_q[b_line];
    assign b_wait  = wt_q[b_line];
    assign b_pend  = pend_q[b_line];

endmodule

// File: rtl/coh_req_policy.sv
module coh_req_policy
    import coh_home_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int DATA_W = 16,
    parameter int NID_W  = 2
) (
    input  logic              kind,
    input  logic [NID_W-1:0]  src,
    input  line_state_e       cur_state,
    input  logic [NODES-1:0]  cur_vec,
    input  wait_e             cur_wait,
    input  logic [NID_W-1:0]  cur_pend,
    input  logic [DATA_W-1:0] cur_data,
    output rsp_kind_e         r_kind,
    output logic [NODES-1:0]  r_nodes,
    output logic [DATA_W-1:0] r_data,
    output logic              upd,
    output line_state_e       nx_state,
    output logic [NODES-1:0]  nx_vec,
    output wait_e             nx_wait,
    output logic [NID_W-1:0]  nx_pend
);

    localparam logic [NODES-1:0] ONE = {{(NODES-1){1'b0}}, 1'b1};

    logic [NODES-1:0] src_bit;
    logic [NODES-1:0] others;

    assign src_bit = ONE << src;
    assign others  = cur_vec & ~src_bit;

    always_comb begin
        r_kind   = RK_REFUSE;
        r_nodes  = '0;
        r_data   = '0;
        upd      = 1'b0;
        nx_state = cur_state;
        nx_vec   = cur_vec;
        nx_wait  = cur_wait;
        nx_pend  = cur_pend;
        if (cur_wait == WT_NONE) begin
            upd = 1'b1;
            if (cur_state == LS_M) begin
                r_kind  = RK_OWNER;
                r_nodes = cur_vec;
                nx_wait = (kind == REQ_READ) ? WT_WB_SHR : WT_WB_EXC;
                nx_pend = src;
            end else if (others == '0) begin
                r_kind   = (kind == REQ_READ) ? RK_DATA_E : RK_DATA_M;
                r_data   = cur_data;
                nx_state = (kind == REQ_READ) ? LS_E : LS_M;
                nx_vec   = src_bit;
            end else if (kind == REQ_READ) begin
                r_kind   = RK_DATA_S;
                r_data   = cur_data;
                nx_state = LS_S;
                nx_vec   = cur_vec | src_bit;
            end else begin
                r_kind  = RK_HOLDERS;
                r_nodes = others;
                r_data  = cur_data;
                nx_wait = WT_DONE;
                nx_pend = src;
            end
        end
    end

endmodule

// File: rtl/coh_evt_policy.sv
module coh_evt_policy
    import coh_home_pkg::*;
#(
    parameter int NODES = 4,
    parameter int NID_W = 2
) (
    input  logic              wb_fire,
    input  logic              cpl_fire,
    input  logic [NID_W-1:0]  ev_src,
    input  line_state_e       cur_state,
    input  logic [NODES-1:0]  cur_vec,
    input  wait_e             cur_wait,
    input  logic [NID_W-1:0]  cur_pend,
    output logic              upd,
    output logic              data_en,
    output line_state_e       nx_state,
    output logic [NODES-1:0]  nx_vec,
    output wait_e             nx_wait
);

    localparam logic [NODES-1:0] ONE = {{(NODES-1){1'b0}}, 1'b1};

    logic [NODES-1:0] pend_bit;
    logic             from_owner;

    assign pend_bit   = ONE << cur_pend;
    assign from_owner = (cur_state == LS_M) && cur_vec[ev_src];

    always_comb begin
        upd      = 1'b0;
        data_en  = 1'b0;
        nx_state = cur_state;
        nx_vec   = cur_vec;
        nx_wait  = cur_wait;
        if (wb_fire && from_owner && (cur_wait != WT_DONE)) begin
            upd     = 1'b1;
            data_en = 1'b1;
            nx_wait = WT_NONE;
            if (cur_wait == WT_WB_SHR) begin
                nx_state = LS_S;
                nx_vec   = cur_vec | pend_bit;
            end else if (cur_wait == WT_WB_EXC) begin
                nx_state = LS_M;
                nx_vec   = pend_bit;
            end else begin
                nx_state = LS_I;
                nx_vec   = '0;
            end
        end else if (cpl_fire && (cur_wait == WT_DONE) && (ev_src == cur_pend)) begin
            upd      = 1'b1;
            nx_state = LS_M;
            nx_vec   = pend_bit;
            nx_wait  = WT_NONE;
        end
    end

endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir
    import coh_home_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int LINES  = 8,
    parameter int DATA_W = 16,
    localparam int NID_W = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int LID_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_kind,
    input  logic [NID_W-1:0]  req_src,
    input  logic [LID_W-1:0]  req_line,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [2:0]        rsp_kind,
    output logic [NID_W-1:0]  rsp_dst,
    output logic [LID_W-1:0]  rsp_line,
    output logic [NODES-1:0]  rsp_nodes,
    output logic [DATA_W-1:0] rsp_data,
    input  logic              wb_valid,
    output logic              wb_ready,
    input  logic [NID_W-1:0]  wb_src,
    input  logic [LID_W-1:0]  wb_line,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              cpl_valid,
    output logic              cpl_ready,
    input  logic [NID_W-1:0]  cpl_src,
    input  logic [LID_W-1:0]  cpl_line
);

    logic req_fire, wb_fire, cpl_fire;
    logic [LID_W-1:0] ev_line;
    logic [NID_W-1:0] ev_src;

    assign wb_ready  = 1'b1;
    assign cpl_ready = !wb_valid;
    assign req_ready = !rsp_valid && !wb_valid && !cpl_valid;
    assign req_fire  = req_valid && req_ready;
    assign wb_fire   = wb_valid;
    assign cpl_fire  = cpl_valid && cpl_ready;
    assign ev_line   = wb_valid ? wb_line : cpl_line;
    assign ev_src    = wb_valid ? wb_src : cpl_src;

    line_state_e       a_state, b_state;
    logic [NODES-1:0]  a_vec, b_vec;
    wait_e             a_wait, b_wait;
    logic [NID_W-1:0]  a_pend, b_pend;
    logic [DATA_W-1:0] a_data;

    rsp_kind_e         q_kind;
    logic [NODES-1:0]  q_nodes;
    logic [DATA_W-1:0] q_data;
    logic              q_upd;
    line_state_e       q_state;
    logic [NODES-1:0]  q_vec;
    wait_e             q_wait;
    logic [NID_W-1:0]  q_pend;

    logic              e_upd, e_data_en;
    line_state_e       e_state;
    logic [NODES-1:0]  e_vec;
    wait_e             e_wait;

    logic              wr_en, wr_data_en;
    logic [LID_W-1:0]  wr_line;
    line_state_e       wr_state;
    logic [NODES-1:0]  wr_vec;
    wait_e             wr_wait;
    logic [NID_W-1:0]  wr_pend;

    coh_dir_store #(
        .NODES(NODES), .LINES(LINES), .DATA_W(DATA_W), .NID_W(NID_W), .LID_W(LID_W)
    ) u_store (
        .clk(clk), .rst(rst),
        .a_line(req_line), .a_state(a_state), .a_vec(a_vec), .a_wait(a_wait),
        .a_pend(a_pend), .a_data(a_data),
        .b_line(ev_line), .b_state(b_state), .b_vec(b_vec), .b_wait(b_wait),
        .b_pend(b_pend),
        .wr_en(wr_en), .wr_line(wr_line), .wr_state(wr_state), .wr_vec(wr_vec),
        .wr_wait(wr_wait), .wr_pend(wr_pend), .wr_data_en(wr_data_en),
        .wr_data(wb_data)
    );

    coh_req_policy #(.NODES(NODES), .DATA_W(DATA_W), .NID_W(NID_W)) u_req (
        .kind(req_kind), .src(req_src),
        .cur_state(a_state), .cur_vec(a_vec), .cur_wait(a_wait), .cur_pend(a_pend),
        .cur_data(a_data),
        .r_kind(q_kind), .r_nodes(q_nodes), .r_data(q_data), .upd(q_upd),
        .nx_state(q_state), .nx_vec(q_vec), .nx_wait(q_wait), .nx_pend(q_pend)
    );

    coh_evt_policy #(.NODES(NODES), .NID_W(NID_W)) u_evt (
        .wb_fire(wb_fire), .cpl_fire(cpl_fire), .ev_src(ev_src),
        .cur_state(b_state), .cur_vec(b_vec), .cur_wait(b_wait), .cur_pend(b_pend),
        .upd(e_upd), .data_en(e_data_en),
        .nx_state(e_state), .nx_vec(e_vec), .nx_wait(e_wait)
    );

    always_comb begin
        if (req_fire) begin
            wr_en      = q_upd;
            wr_line    = req_line;
            wr_state   = q_state;
            wr_vec     = q_vec;
            wr_wait    = q_wait;
            wr_pend    = q_pend;
            wr_data_en = 1'b0;
        end else begin
            wr_en      = e_upd;
            wr_line    = ev_line;
            wr_state   = e_state;
            wr_vec     = e_vec;
            wr_wait    = e_wait;
            wr_pend    = b_pend;
            wr_data_en = e_data_en;
        end
    end

    rsp_kind_e rsp_kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_kind_q <= RK_REFUSE;
            rsp_dst    <= '0;
            rsp_line   <= '0;
            rsp_nodes  <= '0;
            rsp_data   <= '0;
        end else if (req_fire) begin
            rsp_valid  <= 1'b1;
            rsp_kind_q <= q_kind;
            rsp_dst    <= req_src;
            rsp_line   <= req_line;
            rsp_nodes  <= q_nodes;
            rsp_data   <= q_data;
        end else if (rsp_ready) begin
            rsp_valid  <= 1'b0;
        end
    end

    assign rsp_kind = rsp_kind_q;

    AST_REFUSE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_fire && (a_wait != WT_NONE)) |=> (rsp_valid && (rsp_kind == RK_REFUSE))); // R8
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_kind) && $stable(rsp_nodes)
                                       && $stable(rsp_data) && $stable(rsp_dst))); // R11
    AST_HOLDERS_EXCLUDE_DST: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_kind == RK_HOLDERS)) |-> ((rsp_nodes != '0) && !rsp_nodes[rsp_dst])); // R5
    AST_OWNER_ONE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_kind == RK_OWNER)) |-> ($countones(rsp_nodes) == 1)); // R6

endmodule

// File: tb/sim_coh_home_dir.sv
module sim_coh_home_dir;

    localparam int CLK_PERIOD = 10;
    localparam int NODES = 4;
    localparam int LINES = 8;
    localparam int DW    = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic req_valid = 1'b0, req_kind = 1'b0;
    logic [1:0] req_src = '0;
    logic [2:0] req_line = '0;
    logic req_ready;
    logic rsp_valid, rsp_ready = 1'b1;
    logic [2:0] rsp_kind;
    logic [1:0] rsp_dst;
    logic [2:0] rsp_line;
    logic [3:0] rsp_nodes;
    logic [DW-1:0] rsp_data;
    logic wb_valid = 1'b0, wb_ready;
    logic [1:0] wb_src = '0;
    logic [2:0] wb_line = '0;
    logic [DW-1:0] wb_data = '0;
    logic cpl_valid = 1'b0, cpl_ready;
    logic [1:0] cpl_src = '0;
    logic [2:0] cpl_line = '0;

    coh_home_dir #(.NODES(NODES), .LINES(LINES), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_src(req_src), .req_line(req_line),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
        .rsp_dst(rsp_dst), .rsp_line(rsp_line), .rsp_nodes(rsp_nodes), .rsp_data(rsp_data),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_src(wb_src), .wb_line(wb_line),
        .wb_data(wb_data),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_src(cpl_src), .cpl_line(cpl_line)
    );

    typedef struct packed {
        logic [2:0]    kind;
        logic [1:0]    dst;
        logic [2:0]    line;
        logic [3:0]    nodes;
        logic [DW-1:0] data;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && rsp_valid && rsp_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11", "unexpected response kind", 32'(rsp_kind), 32'hF);
            end else begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rsp_kind == e.kind, t, "kind", 32'(rsp_kind), 32'(e.kind));
                if (rsp_kind == e.kind) begin
                    check(rsp_dst == e.dst && rsp_line == e.line && rsp_nodes == e.nodes, t,
                          "dst/line/nodes", {rsp_dst, rsp_line, rsp_nodes},
                          {e.dst, e.line, e.nodes});
                    if (e.kind <= 3'd3)
                        check(rsp_data == e.data, t, "data", 32'(rsp_data), 32'(e.data));
                end
            end
        end
    end

    task automatic do_req(input logic k, input logic [1:0] s, input logic [2:0] l,
                          input logic [2:0] ek, input logic [3:0] en,
                          input logic [DW-1:0] ed, input string tag);
        exp_q.push_back('{kind: ek, dst: s, line: l, nodes: en, data: ed});
        tag_q.push_back(tag);
        @(posedge clk); #1;
        req_valid = 1'b1; req_kind = k; req_src = s; req_line = l;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic do_wb(input logic [1:0] s, input logic [2:0] l, input logic [DW-1:0] d);
        @(posedge clk); #1;
        wb_valid = 1'b1; wb_src = s; wb_line = l; wb_data = d;
        @(posedge clk); #1;
        wb_valid = 1'b0;
    endtask

    task automatic do_cpl(input logic [1:0] s, input logic [2:0] l);
        @(posedge clk); #1;
        cpl_valid = 1'b1; cpl_src = s; cpl_line = l;
        do @(negedge clk); while (!cpl_ready);
        @(posedge clk); #1;
        cpl_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R11", "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'd1);

        // line 1: clean sharing, then exclusive with invalidations
        do_req(1'b0, 2'd0, 3'd1, 3'd0, 4'b0000, 16'h0000, "R2");
        do_req(1'b0, 2'd1, 3'd1, 3'd1, 4'b0000, 16'h0000, "R3");
        do_req(1'b0, 2'd2, 3'd1, 3'd1, 4'b0000, 16'h0000, "R3");
        do_req(1'b1, 2'd1, 3'd1, 3'd3, 4'b0101, 16'h0000, "R5");
        do_req(1'b0, 2'd3, 3'd1, 3'd5, 4'b0000, 16'h0000, "R8");
        do_cpl(2'd2, 3'd1);
        do_req(1'b0, 2'd3, 3'd1, 3'd5, 4'b0000, 16'h0000, "R10");
        do_cpl(2'd1, 3'd1);
        do_req(1'b0, 2'd3, 3'd1, 3'd4, 4'b0010, 16'h0000, "R5");
        do_wb(2'd0, 3'd1, 16'hAAAA);
        do_req(1'b1, 2'd0, 3'd1, 3'd5, 4'b0000, 16'h0000, "R8");
        do_wb(2'd1, 3'd1, 16'h1234);
        do_req(1'b1, 2'd0, 3'd1, 3'd3, 4'b1010, 16'h1234, "R6");
        do_cpl(2'd0, 3'd1);
        do_req(1'b1, 2'd2, 3'd1, 3'd4, 4'b0001, 16'h0000, "R7");
        do_wb(2'd0, 3'd1, 16'h5678);
        do_req(1'b0, 2'd3, 3'd1, 3'd4, 4'b0100, 16'h0000, "R7");
        do_wb(2'd2, 3'd1, 16'h9ABC);
        do_req(1'b0, 2'd0, 3'd1, 3'd1, 4'b0000, 16'h9ABC, "R6");

        // line 2: voluntary writeback by the owner
        do_req(1'b1, 2'd3, 3'd2, 3'd2, 4'b0000, 16'h0000, "R4");
        do_wb(2'd3, 3'd2, 16'hBEEF);
        do_req(1'b0, 2'd1, 3'd2, 3'd0, 4'b0000, 16'hBEEF, "R9");

        // line 3: writeback from a non-owner is dropped
        do_req(1'b1, 2'd2, 3'd3, 3'd2, 4'b0000, 16'h0000, "R4");
        do_wb(2'd0, 3'd3, 16'h1111);
        do_req(1'b0, 2'd1, 3'd3, 3'd4, 4'b0100, 16'h0000, "R10");
        do_wb(2'd2, 3'd3, 16'h2222);
        do_req(1'b0, 2'd0, 3'd3, 3'd1, 4'b0000, 16'h2222, "R6");

        // line 4: sole clean holder upgrades without a holder list
        do_req(1'b0, 2'd0, 3'd4, 3'd0, 4'b0000, 16'h0000, "R2");
        do_req(1'b1, 2'd0, 3'd4, 3'd2, 4'b0000, 16'h0000, "R4");
        do_req(1'b0, 2'd1, 3'd4, 3'd4, 4'b0001, 16'h0000, "R6");
        do_wb(2'd0, 3'd4, 16'h3333);
        do_req(1'b0, 2'd2, 3'd4, 3'd1, 4'b0000, 16'h3333, "R3");

        // R11: stalled response holds
        @(posedge clk); #1 rsp_ready = 1'b0;
        do_req(1'b0, 2'd3, 3'd5, 3'd0, 4'b0000, 16'h0000, "R11");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(rsp_valid == 1'b1 && rsp_kind == 3'd0 && rsp_line == 3'd5 && rsp_dst == 2'd3,
                  "R11", "held response", {rsp_valid, rsp_kind, rsp_line, rsp_dst},
                  {1'b1, 3'd0, 3'd5, 2'd3});
            check(req_ready == 1'b0, "R11", "req_ready during stall", 32'(req_ready), 32'd0);
        end
        @(posedge clk); #1 rsp_ready = 1'b1;
        repeat (2) @(posedge clk);

        // R11: writeback takes precedence over completion and requests
        #1;
        wb_valid = 1'b1; wb_src = 2'd0; wb_line = 3'd6; wb_data = 16'h7777;
        cpl_valid = 1'b1; cpl_src = 2'd0; cpl_line = 3'd6;
        @(negedge clk);
        check(cpl_ready == 1'b0, "R11", "cpl_ready during wb", 32'(cpl_ready), 32'd0);
        check(req_ready == 1'b0, "R11", "req_ready during wb", 32'(req_ready), 32'd0);
        @(posedge clk); #1;
        wb_valid = 1'b0; cpl_valid = 1'b0;
        do_req(1'b0, 2'd0, 3'd6, 3'd0, 4'b0000, 16'h0000, "R10");

        repeat (10) @(posedge clk);
        check(exp_q.size() == 0, "R11", "responses outstanding", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule